// File: doc/BRIEF.md
# Port Pin Edge Interrupt Unit

This unit watches the eight input pins of one general-purpose port and turns selected signal transitions into interrupts. Each pin has its own 2-bit mode that picks rising edges, falling edges, both edges, or no detection. When a selected transition is seen, the unit latches a sticky status bit for that pin. It drives one interrupt request for the whole port, and that request stays high while any status bit is set.

The pin levels are asynchronous. Each one passes through a two-flop synchronizer. A transition is found by comparing the synchronized level with the level held on the previous clock. Software services the port by reading the status word. The read returns the latched bits in the same cycle, and the clock edge that ends the read clears them. A transition detected in the same cycle as the read is kept for the next read.

A small control state machine has three states. `ST_PRIME` holds detection off after reset until the synchronizer and the history flop carry real pin levels. `ST_IDLE` means no status bit is set. `ST_PEND` means at least one bit is set and the request is driven. The transitions are:
- PRIME→IDLE once the priming count completes.
- IDLE→PEND when the next status word is nonzero.
- PEND→IDLE when the next status word is zero.

Nothing in the unit depends on a power state, so detection works whenever its clock runs.

Top module: `port_edge_irq`

## Requirements
- R1: While reset is held and on the first cycle after it, `irq` is 0 and `rd_data` is 0. A read issued after reset returns 0.
- R2: Mode code 2'b01 in `cfg_mode[2p+1:2p]` sets status bit p on a 0→1 transition of `pin_i[p]` and never on a 1→0 transition.
- R3: Mode code 2'b10 sets status bit p on a 1→0 transition and never on a 0→1 transition.
- R4: Mode code 2'b11 sets status bit p on a transition in either direction.
- R5: Mode code 2'b00 never sets status bit p, whatever the pin does.
- R6: Status bits are sticky. Once set, a bit stays set until a read, and events on several pins build up as independent bits.
- R7: While `rd_stb` is 1, `rd_data` shows the current status word, with bit p belonging to pin p. The clock edge that ends the read clears every bit. While `rd_stb` is 0, `rd_data` is 0.
- R8: A pin event detected in the same cycle as a read is not lost. The read does not return it, and the next read does.
- R9: `irq` is 1 exactly when at least one status bit is set.
- R10: A pin level present when reset is released causes no event. A pin change applied before clock edge k shows up in the status word and on `irq` at edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous pin levels |
| cfg_mode | input | 16 | Per-pin 2-bit edge mode, pin p in bits [2p+1:2p] |
| rd_stb | input | 1 | Status read strobe; clears status at the end of the cycle |
| rd_data | output | 8 | Status word during a read, otherwise zero |
| irq | output | 1 | Port interrupt request |

## Verification
If a status bit gets stuck or is lost, the next read shows it: either a bit with no matching event, or an expected bit that is missing. The interrupt line follows at the same clock edge. If the controller state disagrees with the status word, `irq` differs from the OR of the bits that a read returns, in the cycle where they split. A fault in the priming logic shows up as a spurious bit on the first read after reset. A shifted detection latency shows up as `irq` rising one cycle early or late after a pin change.

// File: rtl/port_edge_irq_pkg.sv
package port_edge_irq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RISE = 2'b01,
        MODE_FALL = 2'b10,
        MODE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_PRIME = 2'b00,
        ST_IDLE  = 2'b01,
        ST_PEND  = 2'b10
    } ctrl_state_e;

endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pei_edge_det.sv
module pei_edge_det
    import port_edge_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic       armed,
    input  edge_mode_e mode,
    output logic       evt
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

    always_comb begin
        evt = 1'b0;
        if (armed) begin
            unique case (mode)
                MODE_OFF:  evt = 1'b0;
                MODE_RISE: evt = rise;
                MODE_FALL: evt = fall;
                MODE_BOTH: evt = rise | fall;
                default:   evt = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pei_ctrl.sv
module pei_ctrl
    import port_edge_irq_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int PRIME_COUNT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_evt,
    input  logic            rd_stb,
    output logic [PINS-1:0] status,
    output logic            armed,
    output logic            irq
);
    localparam int CW = $clog2(PRIME_COUNT + 1);

    ctrl_state_e     state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [PINS-1:0] status_q, status_d;

    // status word: read clears, events in the same cycle survive
    always_comb begin
        status_d = (rd_stb ? '0 : status_q) | pin_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (state_q == ST_PRIME) cnt_q <= cnt_q + 1'b1;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (cnt_q == CW'(PRIME_COUNT)) state_d = ST_IDLE;
            ST_IDLE:  if (status_d != '0)            state_d = ST_PEND;
            ST_PEND:  if (status_d == '0)            state_d = ST_IDLE;
            default:                                 state_d = ST_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        armed = 1'b1;
        irq   = 1'b0;
        unique case (state_q)
            ST_PRIME: armed = 1'b0;
            ST_IDLE:  irq   = 1'b0;
            ST_PEND:  irq   = 1'b1;
            default:  armed = 1'b0;
        endcase
    end

    assign status = status_q;
endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
    import port_edge_irq_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_i,
    input  logic [2*PINS-1:0] cfg_mode,
    input  logic              rd_stb,
    output logic [PINS-1:0]   rd_data,
    output logic              irq
);
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] pin_evt;
    logic [PINS-1:0] status_q;
    logic            armed;

    pei_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            pei_edge_det i_det (
                .clk   (clk),
                .rst_n (rst_n),
                .level (pin_sync[p]),
                .armed (armed),
                .mode  (edge_mode_e'(cfg_mode[2*p +: 2])),
                .evt   (pin_evt[p])
            );
        end
    endgenerate

    pei_ctrl #(.PINS(PINS), .PRIME_COUNT(SYNC_STAGES)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_evt (pin_evt),
        .rd_stb  (rd_stb),
        .status  (status_q),
        .armed   (armed),
        .irq     (irq)
    );

    assign rd_data = rd_stb ? status_q : '0;
endmodule

// File: rtl/port_edge_irq_chk.sv
module port_edge_irq_chk #(
    parameter int PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic [PINS-1:0]   rd_data,
    input logic              irq,
    input logic [PINS-1:0]   status,
    input logic [PINS-1:0]   pin_evt,
    input logic              armed,
    input logic [2*PINS-1:0] cfg_mode
);
    logic [PINS-1:0] off_mask;
    always_comb begin
        for (int p = 0; p < PINS; p++) off_mask[p] = (cfg_mode[2*p +: 2] == 2'b00);
    end

    AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_evt != '0) |=> ((status & $past(pin_evt)) == $past(pin_evt))); // R2

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_evt & off_mask) == '0); // R5

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((status & $past(status)) == $past(status))); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (status == $past(pin_evt))); // R8

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> (rd_data == '0)); // R7

    AST_IRQ_IS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status != '0)); // R9

    AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (pin_evt == '0)); // R10
endmodule

bind port_edge_irq port_edge_irq_chk #(.PINS(PINS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .irq      (irq),
    .status   (status_q),
    .pin_evt  (pin_evt),
    .armed    (armed),
    .cfg_mode (cfg_mode)
);

// File: tb/test_port_edge_irq.sv
`timescale 1ns/1ps
module test_port_edge_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = 8'h00;
    logic [15:0] cfg_mode = 16'h0000;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    port_edge_irq i_port_edge_irq (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_mode(cfg_mode),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] val);
        @(negedge clk);
        rd_stb = 1'b1;
        #1 val = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] expect_evt(logic [7:0] oldv, logic [7:0] newv, logic [15:0] mode);
        logic [7:0] r;
        for (int p = 0; p < 8; p++) begin
            case (mode[2*p +: 2])
                2'b01:   r[p] = newv[p] & ~oldv[p];
                2'b10:   r[p] = ~newv[p] & oldv[p];
                2'b11:   r[p] = newv[p] ^ oldv[p];
                default: r[p] = 1'b0;
            endcase
        end
        return r;
    endfunction

    initial begin
        logic [7:0] v;
        logic [7:0] acc;
        logic [7:0] cur;
        logic [15:0] md;
        // R1 / R10: pins high across reset
        pin_i = 8'hA5;
        cfg_mode = 16'hFFFF;
        idle(3);
        check("R1 irq in reset", irq, 0);
        check("R1 rd_data in reset", rd_data, 0);
        @(negedge clk) rst_n = 1'b1;
        check("R1 irq after reset", irq, 0);
        idle(6);
        check("R10 no event from reset level", irq, 0);
        do_read(v);
        check("R1 R10 first read", v, 0);

        // exhaustive single-pin sweep: pin x mode x direction
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 2; d++) begin
                    logic [7:0] start;
                    logic [7:0] fin;
                    start = (d == 0) ? (pin_i & ~(8'h1 << p)) : (pin_i | (8'h1 << p));
                    fin = start ^ (8'h1 << p);
                    md = 16'(m) << (2 * p);
                    @(negedge clk);
                    cfg_mode = md;
                    pin_i = start;
                    idle(5);
                    do_read(v);
                    @(negedge clk) pin_i = fin;
                    idle(4);
                    v = expect_evt(start, fin, md);
                    case (m)
                        1: check("R2 rising irq", irq, (v != 0));
                        2: check("R3 falling irq", irq, (v != 0));
                        3: check("R4 both irq", irq, (v != 0));
                        default: check("R5 off irq", irq, 0);
                    endcase
                    acc = v;
                    do_read(v);
                    case (m)
                        1: check("R2 rising status", v, acc);
                        2: check("R3 falling status", v, acc);
                        3: check("R4 both status", v, acc);
                        default: check("R5 off status", v, 0);
                    endcase
                    check("R7 cleared after read", irq, 0);
                end
            end
        end

        // R10 latency: change before edge k, visible at k+2
        cfg_mode = 16'hFFFF;
        idle(4);
        do_read(v);
        @(negedge clk) pin_i = ~pin_i;
        @(negedge clk);
        check("R10 not after edge k", irq, 0);
        @(negedge clk);
        check("R10 not after edge k+1", irq, 0);
        @(negedge clk);
        check("R10 visible after edge k+2", irq, 1);
        do_read(v);
        check("R10 status content", v, 8'hFF);

        // R8: event in same cycle as read
        @(negedge clk) pin_i = pin_i ^ 8'h18;
        @(negedge clk);
        @(negedge clk);
        rd_stb = 1'b1;
        #1 check("R8 read excludes same-cycle event", rd_data, 0);
        @(negedge clk) rd_stb = 1'b0;
        check("R8 event kept irq", irq, 1);
        do_read(v);
        check("R8 event kept status", v, 8'h18);

        // R6/R9: accumulation over arithmetic pattern sweep, mixed modes
        cur = pin_i;
        for (int it = 0; it < 40; it++) begin
            md = 16'((it * 40503 + 12345) & 16'hFFFF);
            @(negedge clk) cfg_mode = md;
            idle(4);
            do_read(v);
            acc = 0;
            for (int st = 0; st < 3; st++) begin
                logic [7:0] nx;
                nx = 8'((cur * 37 + 11 + it * 3 + st) & 8'hFF);
                @(negedge clk) pin_i = nx;
                idle(4);
                acc |= expect_evt(cur, nx, md);
                cur = nx;
                check("R9 irq follows status", irq, (acc != 0));
            end
            do_read(v);
            check("R6 accumulated status", v, acc);
        end

        do_read(v);
        check("R7 empty after read", v, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule